// File: doc/BRIEF.md
# Guarded Floating-Point Sign Unit with Sticky Exception Flags

This functional unit reads a 32-bit IEEE-754 single-precision operand and produces a 32-bit integer that encodes the operand's sign class: 0, +1 or -1 (all ones). An operation is accepted when `op_valid` is high and `op_code` matches the unit's opcode, 152 by default. The result is registered, so it appears one cycle after issue. `dest_we` marks the cycle in which a register file should capture `dest_data`.

A guard word comes with every issue, and only its least significant bit is used. When that bit is 0, the issued operation does nothing: no write strobe, no change to the held result and no flag update.

The unit also holds a five-bit sticky exception-flag register. On each edge it merges its own flag updates with those driven by other floating-point units working in the same cycle. Flags leave the register only through the explicit status-write port. Denormal operands are flushed to zero and raise a flush flag. NaN operands give 0 and raise the invalid flag.

Top module: `float_sign_unit`

## Requirements
- R1: One cycle after an accepted issue with guard bit 0 set, `dest_we` is 1 for that cycle. A finite non-zero normal operand or an infinity gives `dest_data` = 0x00000001 when bit 31 is 0 and 0xFFFFFFFF when bit 31 is 1. The flag register updates on the same edge.
- R2: +0 (0x00000000) and -0 (0x80000000) give `dest_data` = 0 and set no flag.
- R3: A denormal operand (exponent bits 30:23 all 0, mantissa bits 22:0 non-zero) gives 0 and sets flag bit 1 (flush-to-zero).
- R4: A NaN operand (exponent all 1, mantissa non-zero, quiet or signaling) gives 0 and sets flag bit 0 (invalid). An infinity sets no flag.
- R5: Only `guard[0]` is used. With `guard[0]` = 0, an issue produces no `dest_we`, leaves `dest_data` unchanged and sets no flag of this unit, whatever the upper guard bits are.
- R6: An issue is accepted only when `op_valid` = 1 and `op_code` = 152. Any other opcode has no effect on `dest_we`, `dest_data` or `flags`.
- R7: Flag bits are sticky. With `flag_wr_en` = 0, a set bit stays set, including across later issues that raise nothing.
- R8: Each flag bit's next value is the OR of its current value, this unit's update and every bit of the matching position in each five-bit slice of `ext_set`.
- R9: With `flag_wr_en` = 1, `flags` becomes `flag_wr_data` ORed with all set bits of the same cycle. This is the only way to clear a flag.
- R10: After reset, `dest_we` = 0, `dest_data` = 0 and `flags` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Issue strobe |
| op_code | input | 8 | Opcode; the unit responds to 152 |
| guard | input | 32 | Guard value; only bit 0 is used |
| operand | input | 32 | Single-precision operand |
| ext_set | input | 5*N_EXT | Flag set bits from other floating-point units, one 5-bit slice per unit |
| flag_wr_en | input | 1 | Explicit status write |
| flag_wr_data | input | 5 | Value for the explicit status write |
| dest_we | output | 1 | Destination write strobe |
| dest_data | output | 32 | Integer sign result (0, 1 or 0xFFFFFFFF) |
| flags | output | 5 | Sticky flags: bit 0 invalid, bit 1 flush-to-zero, bits 2-4 external only |

## Verification
A vector table sends each operand class through the unit: positive and negative normals, the smallest negative normal, both zeros, denormals of either sign, both infinities, and quiet and signaling NaNs. This separates sign decoding from the zero, flush and NaN paths, and it shows which flag each class raises. Directed cases then show that a clear guard bit or a foreign opcode leaves `dest_data` and `flags` untouched. They also check that flags persist, that external set bits merge with this unit's bits in one cycle, and that an explicit write both clears flags and is ORed with a flag raised on the same edge.

// File: rtl/float_sign_unit.sv
module float_sign_unit #(
  parameter int          N_EXT  = 2,
  parameter logic [7:0]  OPCODE = 8'd152
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [7:0]         op_code,
  input  logic [31:0]        guard,
  input  logic [31:0]        operand,
  input  logic [5*N_EXT-1:0] ext_set,
  input  logic               flag_wr_en,
  input  logic [4:0]         flag_wr_data,
  output logic               dest_we,
  output logic [31:0]        dest_data,
  output logic [4:0]         flags
);
  localparam int FW    = 5;
  localparam int F_INV = 0;
  localparam int F_FTZ = 1;

  logic        unused_guard;
  logic        fire;
  logic [7:0]  expo;
  logic        man_nz, is_nan, is_den, is_zero;
  logic [31:0] result;
  logic [FW-1:0] own_set, ext_or, all_set;

  assign unused_guard = ^guard[31:1];
  assign fire    = op_valid && (op_code == OPCODE) && guard[0];
  assign expo    = operand[30:23];
  assign man_nz  = |operand[22:0];
  assign is_nan  = (expo == 8'hFF) && man_nz;
  assign is_den  = (expo == 8'h00) && man_nz;
  assign is_zero = (expo == 8'h00) && !man_nz;

  assign result = (is_nan || is_den || is_zero) ? 32'h0 :
                  operand[31] ? 32'hFFFF_FFFF : 32'h1;

  always_comb begin
    own_set        = '0;
    own_set[F_INV] = fire && is_nan;
    own_set[F_FTZ] = fire && is_den;
  end

  always_comb begin
    ext_or = '0;
    for (int i = 0; i < N_EXT; i++) ext_or = ext_or | ext_set[i*FW +: FW];
  end

  assign all_set = own_set | ext_or;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_we   <= 1'b0;
      dest_data <= '0;
      flags     <= '0;
    end else begin
      dest_we <= fire;
      if (fire) dest_data <= result;
      flags <= (flag_wr_en ? flag_wr_data : flags) | all_set;
    end
  end

  // R1
  sign_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dest_we |-> (dest_data == 32'h0 || dest_data == 32'h1 || dest_data == 32'hFFFF_FFFF));

  // R5
  guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPCODE && !guard[0]) |=> (!dest_we && $stable(dest_data)));

  // R6
  wrong_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != OPCODE) |=> (!dest_we && $stable(dest_data)));

  // R4
  nan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPCODE && guard[0] && operand[30:23] == 8'hFF && operand[22:0] != 0)
    |=> (flags[F_INV] && dest_data == 32'h0));

  // R3
  ftz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPCODE && guard[0] && operand[30:23] == 8'h00 && operand[22:0] != 0)
    |=> (flags[F_FTZ] && dest_data == 32'h0));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr_en |=> ((flags & $past(flags)) == $past(flags)));

  // R8
  ext_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_set[FW-1:0] != '0) |=> ((flags & $past(ext_set[FW-1:0])) == $past(ext_set[FW-1:0])));

  // R9
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !op_valid && ext_set == '0) |=> (flags == $past(flag_wr_data)));
endmodule

// File: tb/test_float_sign_unit.sv
module test_float_sign_unit;
  localparam int N_EXT = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_code = 8'd0;
  logic [31:0] guard = 32'd0;
  logic [31:0] operand = 32'd0;
  logic [5*N_EXT-1:0] ext_set = '0;
  logic flag_wr_en = 1'b0;
  logic [4:0] flag_wr_data = 5'd0;
  logic dest_we;
  logic [31:0] dest_data;
  logic [4:0] flags;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  float_sign_unit #(.N_EXT(N_EXT)) i_float_sign_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .guard(guard), .operand(operand), .ext_set(ext_set),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .dest_we(dest_we), .dest_data(dest_data), .flags(flags));

  // {operand, expected result, expected flags}
  localparam logic [68:0] VECS [13] = '{
    {32'h40400000, 32'h00000001, 5'b00000},  // R1 +3.0
    {32'hBF800000, 32'hFFFFFFFF, 5'b00000},  // R1 -1.0
    {32'h80800000, 32'hFFFFFFFF, 5'b00000},  // R1 smallest negative normal
    {32'h7F7FFFFF, 32'h00000001, 5'b00000},  // R1 largest normal
    {32'hFF800000, 32'hFFFFFFFF, 5'b00000},  // R1 R4 -inf
    {32'h7F800000, 32'h00000001, 5'b00000},  // R1 R4 +inf
    {32'h00000000, 32'h00000000, 5'b00000},  // R2 +0
    {32'h80000000, 32'h00000000, 5'b00000},  // R2 -0
    {32'h80400000, 32'h00000000, 5'b00010},  // R3 negative denormal
    {32'h00000001, 32'h00000000, 5'b00010},  // R3 tiny positive denormal
    {32'hFFFFFFFF, 32'h00000000, 5'b00001},  // R4 quiet NaN
    {32'h7FC00000, 32'h00000000, 5'b00001},  // R4 quiet NaN
    {32'h7F800001, 32'h00000000, 5'b00001}   // R4 signaling NaN
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive for one cycle; outputs are observed at the following negedge
  task automatic issue(input logic [7:0] opc, input logic [31:0] g, input logic [31:0] op);
    @(negedge clk);
    op_valid = 1'b1; op_code = opc; guard = g; operand = op;
    @(negedge clk);
    op_valid = 1'b0; op_code = 8'd0; guard = 32'd0;
  endtask

  task automatic write_flags(input logic [4:0] v);
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_data = v;
    @(negedge clk);
    flag_wr_en = 1'b0; flag_wr_data = 5'd0;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 dest_we", {31'd0, dest_we}, 32'd0);
    check("R10 dest_data", dest_data, 32'd0);
    check("R10 flags", {27'd0, flags}, 32'd0);
    rst_n = 1'b1;

    foreach (VECS[k]) begin
      write_flags(5'd0);
      issue(8'd152, 32'd1, VECS[k][68:37]);
      check("R1 dest_we", {31'd0, dest_we}, 32'd1);
      check("R1-R4 dest_data", dest_data, VECS[k][36:5]);
      check("R2-R4 flags", {27'd0, flags}, {27'd0, VECS[k][4:0]});
    end

    // R5: guard LSB clear with upper bits set, NaN operand
    write_flags(5'd0);
    issue(8'd152, 32'd1, 32'hC0000000);
    issue(8'd152, 32'hFFFFFFFE, 32'hFFFFFFFF);
    check("R5 no dest_we", {31'd0, dest_we}, 32'd0);
    check("R5 dest_data held", dest_data, 32'hFFFFFFFF);
    check("R5 flags unaffected", {27'd0, flags}, 32'd0);

    // R6: foreign opcode
    issue(8'd153, 32'd1, 32'h00000001);
    check("R6 no dest_we", {31'd0, dest_we}, 32'd0);
    check("R6 dest_data held", dest_data, 32'hFFFFFFFF);
    check("R6 flags unaffected", {27'd0, flags}, 32'd0);

    // R7: sticky across a clean issue
    issue(8'd152, 32'd1, 32'h7FC00000);
    issue(8'd152, 32'd1, 32'h3F800000);
    check("R7 dest_data", dest_data, 32'h00000001);
    check("R7 invalid sticky", {27'd0, flags}, 32'd1);

    // R8: external sets merge with own denormal flag in the same edge
    write_flags(5'd0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'd152; guard = 32'd1; operand = 32'h00400000;
    ext_set = {5'b10000, 5'b01000};
    @(negedge clk);
    op_valid = 1'b0; ext_set = '0;
    check("R8 merged flags", {27'd0, flags}, 32'b11010);
    check("R8 dest_data", dest_data, 32'd0);

    // R9: explicit clear
    write_flags(5'd0);
    check("R9 clear", {27'd0, flags}, 32'd0);

    // R9: write ORed with same-cycle own set
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_data = 5'b00100;
    op_valid = 1'b1; op_code = 8'd152; guard = 32'd1; operand = 32'hFFC00000;
    @(negedge clk);
    flag_wr_en = 1'b0; op_valid = 1'b0;
    check("R9 write or set", {27'd0, flags}, 32'b00101);

    // R9: write replaces existing value
    write_flags(5'b00010);
    check("R9 load", {27'd0, flags}, 32'b00010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule